// File: doc/BRIEF.md
# EEPROM Command and Write Sequencer

This block implements the command layer of a small serial EEPROM with 128 bytes of storage. It sits behind a two-wire slave front end. The front end detects bus START and STOP conditions, shifts bytes in and out, and drives the acknowledge bit. The sequencer decides whether each received byte is acknowledged. It decodes the device select code against a 3-bit chip-select strap and captures the byte address. Write data is collected into an eight-entry staging buffer. On a STOP that closes a write command, a self-timed programming cycle copies the staged bytes into a register-file array.

Two burst shapes are supported. With the mode input low, page write accepts bytes that wrap inside one 8-byte row. With the mode input high, multibyte write accepts up to four consecutive bytes, which may spill into the next row; in that case the programming time doubles. A write-control input can be enabled by a parameter. When it is enabled, write control held high at any point from START through the address byte blocks the write, and multibyte mode is no longer available.

Reads return the byte at the internal pointer and advance it, so current-address, random and sequential reads all come from the same mechanism. The block reports busy for the whole programming cycle and ignores the bus during that time.

Top module: `eeseq_top`

## Requirements
- R1: A received byte after START is a select code. It is acknowledged only when bits 7..4 are 1010 and bits 3..1 equal `chip_sel_i`. Bit 0 = 1 selects read and bit 0 = 0 selects write. A mismatched code is not acknowledged and the block then waits for the next START.
- R2: After a write select code, the next byte is the address byte and is always acknowledged. Only bits 6..0 form the address; bit 7 is ignored.
- R3: With `mode_i` = 0, page write acknowledges every data byte. The address wraps within the current 8-byte row (bits 6..3 held). A byte landing on an already-filled position overwrites it.
- R4: With `mode_i` = 1 and WC_EN = 0, multibyte write stores up to 4 bytes at consecutive addresses, wrapping from 127 to 0. A fifth or later data byte is not acknowledged and not written.
- R5: A single data byte followed by STOP is written at either level of `mode_i`.
- R6: A STOP ending a write with at least one accepted data byte starts programming. `busy_o` is high for exactly PROG_CYCLES cycles starting the cycle after STOP. The array shows the new data once busy falls.
- R7: In multibyte mode, if the accepted bytes span two 8-byte rows, busy lasts 2*PROG_CYCLES cycles.
- R8: When WC_EN = 1 and `wr_ctrl_i` is high in any cycle from START through the address byte, data bytes are not acknowledged, no programming starts and memory is unchanged. `wr_ctrl_i` high only after the address byte has no effect. When WC_EN = 0, `wr_ctrl_i` is ignored.
- R9: When WC_EN = 1, `mode_i` is ignored and all writes follow page behaviour (R3), never doubling busy.
- R10: While `busy_o` is high, all bus events are ignored: no acknowledge and no read data.
- R11: In a read command each `rd_req_i` returns the byte at the pointer on `rd_data_o` with `rd_valid_o` one cycle later, then advances the pointer, rolling from 127 to 0. A read with no preceding address continues from the current pointer.
- R12: After `rd_nack_i`, further `rd_req_i` pulses give no `rd_valid_o` until a new START; STOP returns the block to standby.
- R13: A STOP after a write select and address but before any data byte starts no programming cycle.
- R14: Reset clears the array to zero, the pointer to 0 and `busy_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_i | input | 3 | Strap compared with select-code bits 3..1 |
| mode_i | input | 1 | 0 = page write, 1 = multibyte write |
| wr_ctrl_i | input | 1 | Write control (used only when WC_EN = 1) |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_i | input | 1 | One-cycle pulse: STOP seen |
| rx_valid_i | input | 1 | One-cycle pulse: a byte from the master is complete |
| rx_byte_i | input | 8 | Received byte, valid with rx_valid_i |
| rd_req_i | input | 1 | Front end requests the next read byte |
| rd_nack_i | input | 1 | Master did not acknowledge the last read byte |
| ack_o | output | 1 | One-cycle pulse: acknowledge the byte just received |
| rd_valid_o | output | 1 | One-cycle pulse: rd_data_o holds a read byte |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The bench places two copies on shared stimulus wires. The copy with WC_EN = 0 answers select code 0 and the copy with WC_EN = 1 answers select code 5. Each write therefore also checks that the other device stays silent. The write-control window and the forced page behaviour can be checked against plain multibyte behaviour under the same mode level. PROG_CYCLES is set to 20, which makes both busy lengths short enough to count exactly. This separates the 20-cycle row-local case from the 40-cycle row-crossing case, including the crossing that wraps from 127 to 0.

// File: rtl/eeseq_pkg.sv
`timescale 1ns/1ps
package eeseq_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic  vld;
        addr_t a;
        byte_t d;
    } slot_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEL, ST_ADDR, ST_WDATA, ST_READ, ST_HOLD
    } cmd_state_e;

    function automatic logic sel_match(byte_t b, logic [2:0] cs);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == cs);
    endfunction

    // next address inside a row of 2**sw bytes
    function automatic addr_t row_step(addr_t a, int unsigned sw);
        addr_t m;
        m = addr_t'((1 << sw) - 1);
        return (a & ~m) | ((a + addr_t'(1)) & m);
    endfunction

    function automatic addr_t row_of(addr_t a, int unsigned sw);
        return a >> sw;
    endfunction
endpackage

// File: rtl/eeseq_prog_timer.sv
`timescale 1ns/1ps
module eeseq_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic dbl,
    output logic busy,
    output logic commit
);
    localparam int CW = $clog2(2*PROG_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (go)             cnt_q <= dbl ? CW'(2*PROG_CYCLES) : CW'(PROG_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign busy   = (cnt_q != '0);
    assign commit = (cnt_q == CW'(1));

    assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit) |=> busy);
    assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);
endmodule

// File: rtl/eeseq_page_buf.sv
`timescale 1ns/1ps
module eeseq_page_buf
    import eeseq_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    localparam int SW = $clog2(PAGE_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   we,
    input  logic [SW-1:0]          slot,
    input  addr_t                  wa,
    input  byte_t                  wd,
    output slot_t [PAGE_BYTES-1:0] ents
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int s = 0; s < PAGE_BYTES; s++) ents[s] <= '0;
        end else if (we) begin
            ents[slot] <= '{vld: 1'b1, a: wa, d: wd};
        end
    end
endmodule

// File: rtl/eeseq_cell_array.sv
`timescale 1ns/1ps
module eeseq_cell_array
    import eeseq_pkg::*;
#(
    parameter int PAGE_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   commit,
    input  slot_t [PAGE_BYTES-1:0] ents,
    input  addr_t                  rd_addr,
    output byte_t                  rd_q
);
    localparam int DEPTH = 1 << ADDR_W;
    byte_t mem [DEPTH];
    logic [PAGE_BYTES-1:0] vld;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_vld
        assign vld[s] = ents[s].vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int s = 0; s < PAGE_BYTES; s++)
                if (ents[s].vld) mem[ents[s].a] <= ents[s].d;
        end
    end

    assign rd_q = mem[rd_addr];

    assert_commit_has_data_R13: assert property (@(posedge clk) disable iff (rst)
        commit |-> (vld != '0));
endmodule

// File: rtl/eeseq_cmd_ctrl.sv
`timescale 1ns/1ps
module eeseq_cmd_ctrl
    import eeseq_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int MB_BYTES   = 4,
    parameter bit WC_EN      = 1'b0,
    localparam int SW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          rx_valid,
    input  byte_t         rx_byte,
    input  logic          rd_req,
    input  logic          rd_nack,
    input  logic          mode_i,
    input  logic          wc_i,
    input  logic [2:0]    chip_sel,
    input  byte_t         mem_q,
    output addr_t         rd_ptr,
    output logic          buf_clr,
    output logic          buf_we,
    output logic [SW-1:0] buf_slot,
    output addr_t         buf_addr,
    output byte_t         buf_data,
    output logic          prog_go,
    output logic          prog_dbl,
    output logic          ack_o,
    output logic          rd_valid,
    output byte_t         rd_data
);
    localparam int CW = $clog2(PAGE_BYTES + 1);

    cmd_state_e    state_q;
    addr_t         ptr_q, row0_q;
    logic          protect_q, cross_q;
    logic [CW-1:0] cnt_q;
    logic          page_mode, wc_eff, live, accept;

    assign page_mode = WC_EN ? 1'b1 : !mode_i;
    assign wc_eff    = WC_EN && wc_i;
    assign live      = !busy_i && !ev_start && !ev_stop;
    assign accept    = !protect_q && (page_mode || (cnt_q < CW'(MB_BYTES)));

    assign buf_clr  = !busy_i && ev_start;
    assign buf_we   = live && (state_q == ST_WDATA) && rx_valid && accept;
    assign buf_slot = page_mode ? ptr_q[SW-1:0] : cnt_q[SW-1:0];
    assign buf_addr = ptr_q;
    assign buf_data = rx_byte;
    assign prog_go  = !busy_i && ev_stop && (state_q == ST_WDATA) && (cnt_q != '0);
    assign prog_dbl = !page_mode && cross_q;
    assign rd_ptr   = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ptr_q     <= '0;
            row0_q    <= '0;
            protect_q <= 1'b0;
            cross_q   <= 1'b0;
            cnt_q     <= '0;
            ack_o     <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            ack_o    <= 1'b0;
            rd_valid <= 1'b0;
            if (!busy_i) begin
                if (ev_start) begin
                    state_q   <= ST_SEL;
                    protect_q <= wc_eff;
                    cnt_q     <= '0;
                    cross_q   <= 1'b0;
                end else if (ev_stop) begin
                    state_q <= ST_IDLE;
                end else begin
                    case (state_q)
                        ST_SEL: if (rx_valid) begin
                            if (sel_match(rx_byte, chip_sel)) begin
                                ack_o   <= 1'b1;
                                state_q <= rx_byte[0] ? ST_READ : ST_ADDR;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                        ST_ADDR: if (rx_valid) begin
                            ack_o   <= 1'b1;
                            ptr_q   <= rx_byte[ADDR_W-1:0];
                            state_q <= ST_WDATA;
                        end
                        ST_WDATA: if (buf_we) begin
                            ack_o <= 1'b1;
                            ptr_q <= page_mode ? row_step(ptr_q, SW) : ptr_q + addr_t'(1);
                            if (cnt_q != CW'(PAGE_BYTES)) cnt_q <= cnt_q + CW'(1);
                            if (cnt_q == '0)
                                row0_q <= row_of(ptr_q, SW);
                            else if (row_of(ptr_q, SW) != row0_q)
                                cross_q <= 1'b1;
                        end
                        ST_READ: begin
                            if (rd_nack) begin
                                state_q <= ST_HOLD;
                            end else if (rd_req) begin
                                rd_valid <= 1'b1;
                                rd_data  <= mem_q;
                                ptr_q    <= ptr_q + addr_t'(1);
                            end
                        end
                        default: ;
                    endcase
                    if (wc_eff && (state_q == ST_SEL || state_q == ST_ADDR))
                        protect_q <= 1'b1;
                end
            end
        end
    end

    assert_mb_nack_R4: assert property (@(posedge clk) disable iff (rst)
        (live && state_q == ST_WDATA && rx_valid && !page_mode && cnt_q >= CW'(MB_BYTES))
        |=> !ack_o);
    assert_protect_nack_R8: assert property (@(posedge clk) disable iff (rst)
        (live && state_q == ST_WDATA && rx_valid && protect_q) |=> !ack_o);
    assert_quiet_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> (!ack_o && !rd_valid));
    assert_read_state_R11: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(state_q) == ST_READ);
endmodule

// File: rtl/eeseq_top.sv
`timescale 1ns/1ps
module eeseq_top
    import eeseq_pkg::*;
#(
    parameter int PROG_CYCLES = 1000,
    parameter int PAGE_BYTES  = 8,
    parameter int MB_BYTES    = 4,
    parameter bit WC_EN       = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] chip_sel_i,
    input  logic       mode_i,
    input  logic       wr_ctrl_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       rd_req_i,
    input  logic       rd_nack_i,
    output logic       ack_o,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o,
    output logic       busy_o
);
    localparam int SW = $clog2(PAGE_BYTES);

    logic                   busy, commit, buf_clr, buf_we, prog_go, prog_dbl;
    logic [SW-1:0]          buf_slot;
    addr_t                  buf_addr, rd_ptr;
    byte_t                  buf_data, mem_q;
    slot_t [PAGE_BYTES-1:0] ents;

    eeseq_cmd_ctrl #(.PAGE_BYTES(PAGE_BYTES), .MB_BYTES(MB_BYTES), .WC_EN(WC_EN)) u_ctrl (
        .clk(clk), .rst(rst), .busy_i(busy), .ev_start(start_i), .ev_stop(stop_i),
        .rx_valid(rx_valid_i), .rx_byte(rx_byte_i), .rd_req(rd_req_i), .rd_nack(rd_nack_i),
        .mode_i(mode_i), .wc_i(wr_ctrl_i), .chip_sel(chip_sel_i), .mem_q(mem_q),
        .rd_ptr(rd_ptr), .buf_clr(buf_clr), .buf_we(buf_we), .buf_slot(buf_slot),
        .buf_addr(buf_addr), .buf_data(buf_data), .prog_go(prog_go), .prog_dbl(prog_dbl),
        .ack_o(ack_o), .rd_valid(rd_valid_o), .rd_data(rd_data_o)
    );

    eeseq_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .slot(buf_slot),
        .wa(buf_addr), .wd(buf_data), .ents(ents)
    );

    eeseq_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(prog_go), .dbl(prog_dbl), .busy(busy), .commit(commit)
    );

    eeseq_cell_array #(.PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst(rst), .commit(commit), .ents(ents), .rd_addr(rd_ptr), .rd_q(mem_q)
    );

    assign busy_o = busy;
endmodule

// File: tb/tb_eeseq_top.sv
`timescale 1ns/1ps
module tb_eeseq_top;
    localparam int P = 20;
    // {mode, start address, byte count, first data byte}
    localparam logic [31:0] VEC [9] = '{
        32'h00_10_01_5A, 32'h01_21_01_33, 32'h00_30_08_10, 32'h00_3C_06_40,
        32'h00_48_0A_70, 32'h01_52_04_90, 32'h01_56_04_B0, 32'h01_60_05_C0,
        32'h01_7E_03_E0};

    logic clk = 0, rst = 1;
    logic mode = 0, wc = 0, start = 0, stop = 0, rx_valid = 0, rd_req = 0, rd_nack = 0;
    logic [7:0] rx_byte = 0;
    logic ack_a, ack_b, rv_a, rv_b, busy_a, busy_b;
    logic [7:0] rd_a, rd_b;
    logic [7:0] mdl [128];
    logic [7:0] mdl_w [128];
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    eeseq_top #(.PROG_CYCLES(P), .WC_EN(1'b0)) dut (
        .clk(clk), .rst(rst), .chip_sel_i(3'd0), .mode_i(mode), .wr_ctrl_i(wc),
        .start_i(start), .stop_i(stop), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .rd_req_i(rd_req), .rd_nack_i(rd_nack), .ack_o(ack_a), .rd_valid_o(rv_a),
        .rd_data_o(rd_a), .busy_o(busy_a));
    eeseq_top #(.PROG_CYCLES(P), .WC_EN(1'b1)) dut_wc (
        .clk(clk), .rst(rst), .chip_sel_i(3'd5), .mode_i(mode), .wr_ctrl_i(wc),
        .start_i(start), .stop_i(stop), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .rd_req_i(rd_req), .rd_nack_i(rd_nack), .ack_o(ack_b), .rd_valid_o(rv_b),
        .rd_data_o(rd_b), .busy_o(busy_b));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask
    task automatic do_stop();
        @(negedge clk) stop = 1;
        @(negedge clk) stop = 0;
    endtask
    task automatic send(input logic [7:0] b, output bit a);
        @(negedge clk); rx_valid = 1; rx_byte = b;
        @(negedge clk); rx_valid = 0; a = ack_a | ack_b;
    endtask
    task automatic wait_busy(output int n);
        n = 0;
        while (busy_a | busy_b) begin n++; @(negedge clk); end
    endtask
    task automatic rd(input bit nk, output bit v, output logic [7:0] d);
        @(negedge clk) rd_req = 1;
        @(negedge clk) rd_req = 0;
        v = rv_a | rv_b; d = rv_a ? rd_a : rd_b;
        if (nk) begin @(negedge clk) rd_nack = 1; @(negedge clk) rd_nack = 0; end
    endtask
    task automatic open_cmd(input logic [2:0] dev, input bit rw);
        bit a;
        do_start();
        send({4'hA, dev, rw}, a);
        chk("R1 select ack", a, 1);
    endtask
    task automatic set_addr(input logic [2:0] dev, input logic [7:0] ad);
        bit a;
        open_cmd(dev, 0);
        send(ad, a);
        chk("R2 address ack", a, 1);
    endtask
    task automatic readback(input logic [2:0] dev, input logic [7:0] st, input int k, input string tag);
        bit v; logic [7:0] d; int ex;
        set_addr(dev, st);
        open_cmd(dev, 1);
        for (int j = 0; j < k; j++) begin
            rd(j == k-1, v, d);
            ex = (dev == 0) ? mdl[(st + j) & 127] : mdl_w[(st + j) & 127];
            chk({tag, " R11 read valid"}, v, 1);
            chk({tag, " data"}, d, ex);
        end
        do_stop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit a, v; logic [7:0] d; int n, ad, lastad, k;
        logic [7:0] st, d0; bit md, dbl; string tag;
        for (int i = 0; i < 128; i++) begin mdl[i] = 0; mdl_w[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R14: reset state
        chk("R14 busy after reset", busy_a | busy_b, 0);
        open_cmd(3'd0, 1);
        rd(1, v, d);
        chk("R14 read valid", v, 1);
        chk("R14 cleared array", d, 0);
        do_stop();

        // vector table: write bursts then read back
        for (int t = 0; t < 9; t++) begin
            md = VEC[t][24]; st = VEC[t][23:16]; n = VEC[t][15:8]; d0 = VEC[t][7:0];
            tag = (n == 1) ? "R5" : (md ? "R4" : "R3");
            mode = md;
            set_addr(3'd0, st);
            lastad = st;
            for (int i = 0; i < n; i++) begin
                logic [7:0] db;
                db = d0 + 8'(i * 17);
                send(db, a);
                if (!md) begin
                    ad = (st & 8'h78) | ((st + i) & 7);
                    chk({tag, " data ack"}, a, 1);
                    mdl[ad] = db; lastad = ad;
                end else if (i < 4) begin
                    ad = (st + i) & 127;
                    chk({tag, " data ack"}, a, 1);
                    mdl[ad] = db; lastad = ad;
                end else begin
                    chk({tag, " extra byte nack"}, a, 0);
                end
            end
            dbl = md && ((st >> 3) != (lastad >> 3));
            do_stop();
            wait_busy(n);
            chk(dbl ? "R7 doubled busy length" : "R6 busy length", n, dbl ? 2*P : P);
            k = md ? ((VEC[t][15:8] > 4) ? 4 : VEC[t][15:8]) : ((VEC[t][15:8] > 8) ? 8 : VEC[t][15:8]);
            readback(3'd0, st, k, tag);
        end

        // R11: current-address read continues after 0x7E,0x7F,0x00 -> pointer at 1
        open_cmd(3'd0, 1);
        rd(1, v, d);
        chk("R11 current address data", d, mdl[1]);
        // R12: request after master nack gives nothing
        rd(0, v, d);
        chk("R12 no data after nack", v, 0);
        do_stop();

        // R2: bit 7 of address ignored
        mode = 0;
        set_addr(3'd0, 8'h85);
        send(8'hC3, a);
        chk("R2 data ack", a, 1);
        mdl[5] = 8'hC3;
        do_stop(); wait_busy(n);
        readback(3'd0, 8'h05, 1, "R2");

        // R13: stop before data
        set_addr(3'd0, 8'h20);
        do_stop();
        chk("R13 no busy without data", busy_a | busy_b, 0);

        // R10: bus ignored while busy
        set_addr(3'd0, 8'h40);
        send(8'h77, a);
        mdl[8'h40] = 8'h77;
        do_stop();
        do_start();
        send(8'hA1, a);
        chk("R10 no ack while busy", a, 0);
        wait_busy(n);
        readback(3'd0, 8'h40, 1, "R10");

        // R1: nobody answers select code 3
        do_start();
        send(8'hA6, a);
        chk("R1 mismatched select no ack", a, 0);
        do_stop();

        // R8: write control high during select only
        do_start();
        wc = 1;
        send(8'hAA, a);
        chk("R1 select ack wc device", a, 1);
        wc = 0;
        send(8'h10, a);
        send(8'h55, a);
        chk("R8 data nack when protected", a, 0);
        do_stop();
        chk("R8 no programming when protected", busy_a | busy_b, 0);
        // R8: high only during address byte
        open_cmd(3'd5, 0);
        wc = 1; send(8'h11, a); wc = 0;
        send(8'h66, a);
        chk("R8 data nack addr window", a, 0);
        do_stop();
        readback(3'd5, 8'h10, 2, "R8 unchanged");
        // R8: high after address byte has no effect
        set_addr(3'd5, 8'h30);
        wc = 1;
        send(8'h99, a);
        chk("R8 data ack after window", a, 1);
        mdl_w[8'h30] = 8'h99;
        do_stop(); wc = 0;
        wait_busy(n);
        chk("R8 programs after window", n, P);
        // R8: device without the feature ignores write control
        wc = 1;
        set_addr(3'd0, 8'h70);
        send(8'h44, a);
        chk("R8 ignored when disabled", a, 1);
        mdl[8'h70] = 8'h44;
        do_stop(); wc = 0;
        wait_busy(n);
        readback(3'd0, 8'h70, 1, "R8 disabled");
        readback(3'd5, 8'h30, 1, "R8 window");

        // R9: mode high on the write-control variant still behaves as page write
        mode = 1;
        set_addr(3'd5, 8'h0E);
        for (int i = 0; i < 5; i++) begin
            send(8'hA0 + 8'(i), a);
            chk("R9 page ack", a, 1);
            mdl_w[(8'h0E & 8'h78) | ((8'h0E + i) & 7)] = 8'hA0 + 8'(i);
        end
        do_stop();
        wait_busy(n);
        chk("R9 busy not doubled", n, P);
        readback(3'd5, 8'h08, 8, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule